// File: doc/BRIEF.md
# Dual SRAM Buffer Read Port

This block is the buffer-read front end of a serial flash model that holds two independent SRAM page buffers. A host drives a mode-0 SPI bus (clock idle low, input sampled on the rising edge, output changed on the falling edge). While chip select is low, the block takes in an opcode and then a 24-bit address. Depending on the opcode it may also take one dummy byte. It then shifts bytes out of the selected buffer, most significant bit first, for as long as the host keeps clocking. The buffers are filled through a separate parallel preload port, which a test harness uses to set their contents.

The opcode selects the buffer and the clock-rate class. Fast-class opcodes require one dummy byte after the address. Slow-class opcodes start data straight after the address. The two opcodes of the byte-wide interface are also accepted on the serial path and behave like the fast class. A page-size input chooses the buffer geometry: 1056 bytes with an 11-bit byte address, or 1024 bytes with a 10-bit byte address. The remaining bits of the 24-bit field are ignored.

The SPI pins are sampled in the system clock domain. The controller has six named states:
- IDLE: chip select is high.
- OPCODE: collecting the command byte.
- ADDR: collecting three address bytes.
- DUMMY: collecting the dummy byte.
- DATA: streaming output.
- IGNORE: an unknown opcode was received.

Its transitions are:
- Any state goes to IDLE when chip select rises.
- IDLE goes to OPCODE when chip select falls.
- OPCODE goes to ADDR on a known opcode, and to IGNORE on any other value.
- ADDR goes to DUMMY after the 24th bit for a fast-class opcode, and to DATA after the 24th bit for a slow-class opcode.
- DUMMY goes to DATA after its eighth bit.

Top module: `dual_buf_read_port`

## Requirements
- R1: Opcodes 0xD4, 0xD1 and 0x54 read buffer 0. Opcodes 0xD6, 0xD3 and 0x56 read buffer 1.
- R2: For opcodes 0xD4, 0xD6, 0x54 and 0x56, exactly one dummy byte follows the address. For 0xD1 and 0xD3, the first data bit is driven on the SCK falling edge right after the 24th address bit.
- R3: When `page_1024` is 0, the start address is bits [10:0] of the 24-bit address field (sent MSB first), and bits [23:11] are ignored. A value of 1056 or more is reduced by 1056.
- R4: When `page_1024` is 1, the start address is bits [9:0] of the address field, and bits [23:10] are ignored.
- R5: Data leaves MSB first, one bit per SCK falling edge, from consecutive buffer addresses. After the last byte of the buffer (1055 or 1023), the next byte comes from address 0.
- R6: `so_oe` is 0 during the opcode, address and dummy phases. It falls within two clocks after `cs_n` goes high.
- R7: After any other opcode, `so_oe` stays 0 until `cs_n` goes high. The next command is then decoded normally.
- R8: A preload write of `pl_data` to buffer `pl_buf` at address `pl_addr` below 1056 is returned by a later read of that location.
- R9: After reset, `so_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| si | input | 1 | SPI serial data into the block |
| so | output | 1 | SPI serial data out |
| so_oe | output | 1 | Output enable for `so`; 0 means tri-stated |
| page_1024 | input | 1 | 1 selects 1024-byte geometry, 0 selects 1056-byte; change only while `cs_n` is high |
| pl_we | input | 1 | Preload write strobe |
| pl_buf | input | 1 | Preload target buffer |
| pl_addr | input | 11 | Preload byte address |
| pl_data | input | 8 | Preload byte |

## Verification
Random reads mix all six opcodes, both geometries, random upper address bits and burst lengths of one to six bytes. These runs tell apart the buffer selection, the presence or absence of the dummy byte (a wrong count shifts every bit), and the masking of don't-care bits. Directed reads start just below the end of each geometry to expose the wrap point. A start of 2047 in 1056-byte mode checks the modulo reduction. An unsupported opcode followed by clocking checks that the output stays released, and a normal read afterwards checks that the block recovers.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

    localparam int STD_BYTES = 1056;
    localparam int BIN_BYTES = 1024;
    localparam int NBUF      = 2;
    localparam int AW        = $clog2(STD_BYTES);
    localparam int BW        = $clog2(BIN_BYTES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_IGNORE
    } rd_state_t;

    typedef struct packed {
        logic valid;
        logic bsel;
        logic dummy;
    } cmd_info_t;

endpackage

// File: rtl/dbr_edge.sv
module dbr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic sck_rise,
    output logic sck_fall
);
    logic sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    assign sck_rise = sck & ~sck_q;
    assign sck_fall = ~sck & sck_q;
endmodule

// File: rtl/dbr_decode.sv
module dbr_decode
    import dbr_pkg::*;
#(
    parameter bit BYTE_IF_OPS = 1'b1
) (
    input  logic [7:0] opcode,
    output cmd_info_t  info
);
    cmd_info_t serial_info;
    cmd_info_t wide_info;

    always_comb begin
        serial_info = '0;
        unique case (opcode)
            8'hD4: serial_info = '{valid: 1'b1, bsel: 1'b0, dummy: 1'b1};
            8'hD6: serial_info = '{valid: 1'b1, bsel: 1'b1, dummy: 1'b1};
            8'hD1: serial_info = '{valid: 1'b1, bsel: 1'b0, dummy: 1'b0};
            8'hD3: serial_info = '{valid: 1'b1, bsel: 1'b1, dummy: 1'b0};
            default: serial_info = '0;
        endcase
    end

    generate
        if (BYTE_IF_OPS) begin : g_wide
            always_comb begin
                wide_info = '0;
                unique case (opcode)
                    8'h54: wide_info = '{valid: 1'b1, bsel: 1'b0, dummy: 1'b1};
                    8'h56: wide_info = '{valid: 1'b1, bsel: 1'b1, dummy: 1'b1};
                    default: wide_info = '0;
                endcase
            end
        end else begin : g_nowide
            assign wide_info = '0;
        end
    endgenerate

    assign info = serial_info.valid ? serial_info : wide_info;
endmodule

// File: rtl/dbr_ram.sv
module dbr_ram
    import dbr_pkg::*;
#(
    parameter int DEPTH = STD_BYTES,
    parameter int NB    = NBUF,
    localparam int AWL  = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           we,
    input  logic           wsel,
    input  logic [AWL-1:0] waddr,
    input  logic [7:0]     wdata,
    input  logic           rsel,
    input  logic [AWL-1:0] raddr,
    output logic [7:0]     rdata
);
    logic [7:0] rd_each [NB];

    generate
        for (genvar b = 0; b < NB; b++) begin : g_buf
            logic [7:0] mem [DEPTH];
            always_ff @(posedge clk) begin
                if (we && (int'(wsel) == b) && (int'(waddr) < DEPTH))
                    mem[waddr] <= wdata;
            end
            assign rd_each[b] = (int'(raddr) < DEPTH) ? mem[raddr] : 8'h00;
        end
    endgenerate

    assign rdata = rd_each[rsel];
endmodule

// File: rtl/dbr_ctrl.sv
module dbr_ctrl
    import dbr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          si,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          page_1024,
    output logic [7:0]    op_byte,
    input  cmd_info_t     info,
    output logic          rd_sel,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic          so,
    output logic          so_oe
);
    localparam logic [AW-1:0] STD_SIZE = AW'(STD_BYTES);
    localparam logic [AW-1:0] BIN_SIZE = AW'(BIN_BYTES);

    rd_state_t     state_q, state_d;
    logic [2:0]    bit_q;
    logic [1:0]    byte_q;
    logic [6:0]    sh_q;
    logic [15:0]   addr_q;
    logic          sel_q;
    logic          dummy_q;
    logic [AW-1:0] ptr_q;
    logic [2:0]    obit_q;
    logic [6:0]    osh_q;
    logic          so_q;
    logic          oe_q;

    logic [7:0]    full_byte;
    logic          byte_end;
    logic [23:0]   addr24;
    logic [AW-1:0] start_addr;
    logic [AW-1:0] ptr_next;
    logic [AW-1:0] size_now;
    logic          cmd_phase;

    assign full_byte = {sh_q, si};
    assign op_byte   = full_byte;
    assign byte_end  = sck_rise && (bit_q == 3'd7);
    assign addr24    = {addr_q, full_byte};
    assign size_now  = page_1024 ? BIN_SIZE : STD_SIZE;
    assign cmd_phase = (state_q == ST_OPCODE) || (state_q == ST_ADDR) ||
                       (state_q == ST_DUMMY);

    always_comb begin
        if (page_1024) begin
            start_addr = AW'(addr24[BW-1:0]);
        end else if (addr24[AW-1:0] >= STD_SIZE) begin
            start_addr = addr24[AW-1:0] - STD_SIZE;
        end else begin
            start_addr = addr24[AW-1:0];
        end
    end

    assign ptr_next = (ptr_q >= size_now - AW'(1)) ? '0 : ptr_q + AW'(1);

    always_comb begin
        state_d = state_q;
        if (cs_n) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_OPCODE;
                ST_OPCODE: if (byte_end) state_d = info.valid ? ST_ADDR : ST_IGNORE;
                ST_ADDR:   if (byte_end && byte_q == 2'd2)
                               state_d = dummy_q ? ST_DUMMY : ST_DATA;
                ST_DUMMY:  if (byte_end) state_d = ST_DATA;
                ST_DATA:   state_d = ST_DATA;
                ST_IGNORE: state_d = ST_IGNORE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q   <= '0;
            byte_q  <= '0;
            sh_q    <= '0;
            addr_q  <= '0;
            sel_q   <= 1'b0;
            dummy_q <= 1'b0;
            ptr_q   <= '0;
            obit_q  <= '0;
            osh_q   <= '0;
            so_q    <= 1'b0;
            oe_q    <= 1'b0;
        end else if (cs_n) begin
            bit_q  <= '0;
            byte_q <= '0;
            obit_q <= '0;
            oe_q   <= 1'b0;
        end else begin
            if (sck_rise && cmd_phase) begin
                sh_q  <= full_byte[6:0];
                bit_q <= bit_q + 3'd1;
                if (bit_q == 3'd7) begin
                    unique case (state_q)
                        ST_OPCODE: begin
                            sel_q   <= info.bsel;
                            dummy_q <= info.dummy;
                        end
                        ST_ADDR: begin
                            addr_q <= {addr_q[7:0], full_byte};
                            byte_q <= byte_q + 2'd1;
                            if (byte_q == 2'd2) ptr_q <= start_addr;
                        end
                        default: ;
                    endcase
                end
            end
            if (sck_fall && state_q == ST_DATA) begin
                oe_q   <= 1'b1;
                obit_q <= obit_q + 3'd1;
                if (obit_q == 3'd0) begin
                    so_q  <= rd_data[7];
                    osh_q <= rd_data[6:0];
                    ptr_q <= ptr_next;
                end else begin
                    so_q  <= osh_q[6];
                    osh_q <= {osh_q[5:0], 1'b0};
                end
            end
        end
    end

    assign rd_sel  = sel_q;
    assign rd_addr = ptr_q;
    assign so      = so_q;
    assign so_oe   = oe_q;

    AST_OE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> (state_q == ST_DATA)); // R6
    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !so_oe); // R6
    AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> !so_oe); // R7
    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (ptr_q < size_now)); // R5
    AST_SO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && !cs_n && !sck_fall) |=> $stable(so)); // R5
    AST_FAST_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DUMMY) |-> dummy_q); // R2
endmodule

// File: rtl/dual_buf_read_port.sv
module dual_buf_read_port
    import dbr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sck,
    input  logic          si,
    output logic          so,
    output logic          so_oe,
    input  logic          page_1024,
    input  logic          pl_we,
    input  logic          pl_buf,
    input  logic [10:0]   pl_addr,
    input  logic [7:0]    pl_data
);
    logic          sck_rise, sck_fall;
    logic [7:0]    op_byte;
    cmd_info_t     info;
    logic          rd_sel;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;

    dbr_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall)
    );

    dbr_decode #(.BYTE_IF_OPS(1'b1)) u_dec (
        .opcode (op_byte),
        .info   (info)
    );

    dbr_ram #(.DEPTH(STD_BYTES), .NB(NBUF)) u_ram (
        .clk   (clk),
        .we    (pl_we),
        .wsel  (pl_buf),
        .waddr (pl_addr),
        .wdata (pl_data),
        .rsel  (rd_sel),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    dbr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .si        (si),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .page_1024 (page_1024),
        .op_byte   (op_byte),
        .info      (info),
        .rd_sel    (rd_sel),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .so        (so),
        .so_oe     (so_oe)
    );
endmodule

// File: tb/dual_buf_read_port_tb.sv
module dual_buf_read_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        si = 1'b0;
    logic        so, so_oe;
    logic        page_1024 = 1'b0;
    logic        pl_we = 1'b0;
    logic        pl_buf = 1'b0;
    logic [10:0] pl_addr = '0;
    logic [7:0]  pl_data = '0;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;
    logic [7:0] model [2][1056];

    always #2 clk = ~clk;

    dual_buf_read_port dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .so(so), .so_oe(so_oe), .page_1024(page_1024),
        .pl_we(pl_we), .pl_buf(pl_buf), .pl_addr(pl_addr), .pl_data(pl_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int exp_start(input logic [23:0] a, input bit m1024);
        int v;
        if (m1024) return int'(a[9:0]);
        v = int'(a[10:0]);
        return (v >= 1056) ? v - 1056 : v;
    endfunction

    function automatic bit op_buf(input logic [7:0] op);
        return (op == 8'hD6) || (op == 8'hD3) || (op == 8'h56);
    endfunction

    function automatic bit op_dummy(input logic [7:0] op);
        return !((op == 8'hD1) || (op == 8'hD3));
    endfunction

    task automatic bit_cycle(input logic d, output logic q, output logic oe);
        si = d;
        repeat (4) @(negedge clk);
        q = so; oe = so_oe;
        sck = 1'b1;
        repeat (4) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input string req);
        logic q, oe;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(b[i], q, oe);
            if (i == 0) chk(oe == 1'b0, req, oe, 0);
        end
    endtask

    task automatic recv_byte(output logic [7:0] b, output logic oe_all);
        logic q, oe;
        oe_all = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'($urandom_range(1)), q, oe);
            b[i] = q;
            oe_all &= oe;
        end
    endtask

    task automatic end_cmd();
        @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(so_oe == 1'b0, "R6 release", so_oe, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_read(input logic [7:0] op, input logic [23:0] a, input bit m1024,
                           input int n, input string req);
        int size, p;
        logic [7:0] got;
        logic oe;
        bit bsel;
        page_1024 = m1024;
        size = m1024 ? 1024 : 1056;
        p = exp_start(a, m1024);
        bsel = op_buf(op);
        @(negedge clk);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        send_byte(op, "R6 opcode phase");
        send_byte(a[23:16], "R6 addr phase");
        send_byte(a[15:8], "R6 addr phase");
        send_byte(a[7:0], "R6 addr phase");
        if (op_dummy(op)) send_byte(8'($urandom), "R2 dummy phase");
        for (int k = 0; k < n; k++) begin
            recv_byte(got, oe);
            chk(oe == 1'b1, req, oe, 1);
            chk(got == model[bsel][p], req, got, model[bsel][p]);
            p = (p + 1 >= size) ? 0 : p + 1;
        end
        end_cmd();
    endtask

    task automatic preload(input bit b, input int ad, input logic [7:0] d);
        @(negedge clk);
        pl_we = 1'b1; pl_buf = b; pl_addr = 11'(ad); pl_data = d;
        @(negedge clk);
        pl_we = 1'b0;
        model[b][ad] = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] ops [6];
        logic q, oe;
        ops = '{8'hD4, 8'hD1, 8'h54, 8'hD6, 8'hD3, 8'h56};
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        chk(so_oe == 1'b0, "R9 reset", so_oe, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(so_oe == 1'b0, "R9 after reset", so_oe, 0);

        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 1056; i++) begin
                @(negedge clk);
                pl_we = 1'b1; pl_buf = 1'(b); pl_addr = 11'(i);
                pl_data = 8'($urandom);
                model[b][i] = pl_data;
            end
        @(negedge clk);
        pl_we = 1'b0;

        // R8 targeted preload then read back
        preload(1'b0, 100, 8'hA5);
        preload(1'b1, 100, 8'h3C);
        do_read(8'hD1, 24'h000064, 1'b0, 1, "R8 preload buf0");
        do_read(8'hD3, 24'h000064, 1'b0, 1, "R8 preload buf1");

        // R1 all six opcodes, same address, distinct buffers
        preload(1'b0, 5, 8'h11);
        preload(1'b1, 5, 8'hEE);
        foreach (ops[i]) do_read(ops[i], 24'h000005, 1'b0, 2, "R1 buffer select");

        // R2 slow vs fast class at the same place
        do_read(8'hD1, 24'h000200, 1'b1, 3, "R2 no dummy");
        do_read(8'hD4, 24'h000200, 1'b1, 3, "R2 one dummy");

        // R5 wrap in each geometry
        do_read(8'hD4, 24'h00041E, 1'b0, 4, "R5 wrap 1055");
        do_read(8'hD3, 24'hFFFBFE, 1'b1, 4, "R5 wrap 1023");

        // R3 modulo of out-of-range address, upper bits ignored
        do_read(8'hD6, 24'hABC7FF, 1'b0, 2, "R3 modulo 2047");
        do_read(8'hD1, 24'hFFF810, 1'b0, 2, "R3 upper bits");

        // R4 ten-bit address in 1024 mode
        do_read(8'hD4, 24'h0007FF, 1'b1, 2, "R4 ten bits");

        // R7 unknown opcode keeps SO released
        @(negedge clk);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        send_byte(8'h0B, "R7 opcode");
        for (int i = 0; i < 40; i++) begin
            bit_cycle(1'b1, q, oe);
            chk(oe == 1'b0, "R7 unknown opcode", oe, 0);
        end
        end_cmd();
        do_read(8'hD4, 24'h000010, 1'b0, 2, "R7 recovery");

        // random mix
        for (int t = 0; t < 40; t++) begin
            do_read(ops[$urandom_range(5)], 24'($urandom), 1'($urandom_range(1)),
                    int'($urandom_range(6, 1)), "R5 random sequential");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule